// File: doc/BRIEF.md
# Two-Bit JK Excitation State Machine

This block is a small synchronous machine with two state bits, A and B. Each bit is held in a JK flip-flop. A single serial input drives the machine. Fixed excitation logic works out the J and K inputs of both flip-flops from the present state and the input bit. The flip-flops then apply the usual JK rule on each rising clock edge: hold, clear, set or invert.

The machine has no separate output function. What can be observed is the state sequence, and it appears directly on the two state outputs. The state code is written AB, with A as the most significant bit.

The flip-flop primitive is a reusable library cell with a width parameter. A second parameter chooses between a case-decoded implementation and a sum-of-products implementation of the characteristic behaviour; both behave the same.

Top module: `jk_seq_machine`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge loads state code AB = 00. `rst` is active high and synchronous.
- R2: From AB = 00, an edge with `x_in` = 0 moves the machine to 01, and an edge with `x_in` = 1 leaves it at 00.
- R3: From AB = 01, an edge with `x_in` = 0 moves the machine to 11, and an edge with `x_in` = 1 moves it to 10.
- R4: From AB = 10, an edge with `x_in` = 0 moves the machine to 11, and an edge with `x_in` = 1 leaves it at 10.
- R5: From AB = 11, an edge with `x_in` = 0 moves the machine to 00, and an edge with `x_in` = 1 leaves it at 11.
- R6: Bit A follows the JK rule with J = B and K = B AND NOT x. The rule is: J=0,K=0 holds the bit; J=0,K=1 clears it; J=1,K=0 sets it; J=1,K=1 inverts it.
- R7: Bit B follows the same JK rule with J = NOT x and K = A XOR x.
- R8: Reset takes priority over `x_in` from every state. An edge with `rst` high yields 00 whatever the input bit and whatever the prior state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Serial input bit |
| state_a | output | 1 | State bit A (most significant) |
| state_b | output | 1 | State bit B (least significant) |

## Verification
A fixed input walk first visits every state with each input value, so all eight state/input pairs of the transition table are covered. This also separates self-loops from real moves. A long pseudo-random bit stream then mixes runs of ones, which pin the machine in the holding states, with isolated zeros, which drive the 01→11→00 cycle. Resets are issued from non-zero states with both input values, which shows that reset outranks the input. Every step is compared twice: once against the whole-state transition table, and once bit by bit against a JK characteristic model. A fault in the excitation logic and a fault in the flip-flop rule therefore show up under different requirements.

// File: rtl/jk_seq_pkg.sv
package jk_seq_pkg;

   // JK action code: {J,K}
   typedef enum logic [1:0] {
      JK_HOLD = 2'b00,
      JK_CLR  = 2'b01,
      JK_SET  = 2'b10,
      JK_TGL  = 2'b11
   } jk_act_e;

   localparam int STATE_W = 2;
   localparam int IDX_A   = 1;
   localparam int IDX_B   = 0;

   function automatic logic jk_apply(input logic j, input logic k, input logic q);
      jk_act_e act;
      act = jk_act_e'({j, k});
      case (act)
         JK_HOLD: return q;
         JK_CLR:  return 1'b0;
         JK_SET:  return 1'b1;
         default: return ~q;
      endcase
   endfunction

endpackage

// File: rtl/jk_seq_jkff.sv
module jk_seq_jkff
   import jk_seq_pkg::*;
#(
   parameter int               WIDTH   = 1,
   parameter bit               USE_SOP = 1'b0,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] j,
   input  logic [WIDTH-1:0] k,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("jk_seq_jkff: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] q_nxt;

   generate
      if (USE_SOP) begin : g_sop
         // characteristic equation form
         assign q_nxt = (j & ~q) | (~k & q);
      end else begin : g_case
         for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign q_nxt[gi] = jk_apply(j[gi], k[gi], q[gi]);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= q_nxt;
   end

   generate
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_chk
         // R6 R7
         jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!j[gi] && !k[gi]) |=> $stable(q[gi]));
         // R6 R7
         jk_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!j[gi] && k[gi]) |=> !q[gi]);
         // R6 R7
         jk_set_chk: assert property (@(posedge clk) disable iff (rst)
            (j[gi] && !k[gi]) |=> q[gi]);
         // R6 R7
         jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            (j[gi] && k[gi]) |=> (q[gi] != $past(q[gi])));
      end
   endgenerate

endmodule

// File: rtl/jk_seq_excite.sv
module jk_seq_excite (
   input  logic cur_a,
   input  logic cur_b,
   input  logic x_bit,
   output logic ja,
   output logic ka,
   output logic jb,
   output logic kb
);

   // bit A: set side from B, clear side when B with input low
   assign ja = cur_b;
   assign ka = cur_b & ~x_bit;
   // bit B: set side from inverted input, clear side from A vs input mismatch
   assign jb = ~x_bit;
   assign kb = cur_a ^ x_bit;

endmodule

// File: rtl/jk_seq_machine.sv
module jk_seq_machine
   import jk_seq_pkg::*;
#(
   parameter bit FF_USE_SOP = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic x_in,
   output logic state_a,
   output logic state_b
);

   logic [STATE_W-1:0] st;
   logic [STATE_W-1:0] jv;
   logic [STATE_W-1:0] kv;

   jk_seq_excite u_excite (
      .cur_a (st[IDX_A]),
      .cur_b (st[IDX_B]),
      .x_bit (x_in),
      .ja    (jv[IDX_A]),
      .ka    (kv[IDX_A]),
      .jb    (jv[IDX_B]),
      .kb    (kv[IDX_B])
   );

   jk_seq_jkff #(
      .WIDTH   (STATE_W),
      .USE_SOP (FF_USE_SOP),
      .RST_VAL ('0)
   ) u_ff (
      .clk (clk),
      .rst (rst),
      .j   (jv),
      .k   (kv),
      .q   (st)
   );

   assign state_a = st[IDX_A];
   assign state_b = st[IDX_B];

   // R1 R8
   reset_zero_chk: assert property (@(posedge clk)
      rst |=> ({state_a, state_b} == 2'b00));
   // R2
   from00_chk: assert property (@(posedge clk) disable iff (rst)
      ({state_a, state_b} == 2'b00) |=>
         ({state_a, state_b} == ($past(x_in) ? 2'b00 : 2'b01)));
   // R3
   from01_chk: assert property (@(posedge clk) disable iff (rst)
      ({state_a, state_b} == 2'b01) |=>
         ({state_a, state_b} == ($past(x_in) ? 2'b10 : 2'b11)));
   // R4
   from10_chk: assert property (@(posedge clk) disable iff (rst)
      ({state_a, state_b} == 2'b10) |=>
         ({state_a, state_b} == ($past(x_in) ? 2'b10 : 2'b11)));
   // R5
   from11_chk: assert property (@(posedge clk) disable iff (rst)
      ({state_a, state_b} == 2'b11) |=>
         ({state_a, state_b} == ($past(x_in) ? 2'b11 : 2'b00)));

endmodule

// File: tb/jk_seq_machine_tb.sv
module jk_seq_machine_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x_in = 1'b0;
   logic state_a;
   logic state_b;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit first_rst = 1'b1;

   logic [1:0] mdl = 2'b00;
   logic [1:0] q_tab[$];
   logic [1:0] q_jk[$];
   string      q_tag[$];

   always #2 clk = ~clk;

   jk_seq_machine u_dut (
      .clk     (clk),
      .rst     (rst),
      .x_in    (x_in),
      .state_a (state_a),
      .state_b (state_b)
   );

   // transition table from R2..R5
   function automatic logic [1:0] tab_next(input logic [1:0] s, input logic xv);
      case (s)
         2'b00:   return xv ? 2'b00 : 2'b01;
         2'b01:   return xv ? 2'b10 : 2'b11;
         2'b10:   return xv ? 2'b10 : 2'b11;
         default: return xv ? 2'b11 : 2'b00;
      endcase
   endfunction

   function automatic logic jk_rule(input logic q, input logic j, input logic k);
      if (!j && !k) return q;
      if (!j &&  k) return 1'b0;
      if ( j && !k) return 1'b1;
      return ~q;
   endfunction

   function automatic string origin_tag(input logic [1:0] s);
      case (s)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic step(input logic r, input logic xv);
      logic [1:0] nt;
      logic [1:0] nj;
      @(negedge clk);
      rst  = r;
      x_in = xv;
      if (r) begin
         q_tab.push_back(2'b00);
         q_jk.push_back(2'b00);
         q_tag.push_back(first_rst ? "R1" : "R8");
         first_rst = 1'b0;
         mdl = 2'b00;
      end else begin
         nt = tab_next(mdl, xv);
         nj[1] = jk_rule(mdl[1], mdl[0], mdl[0] & ~xv);
         nj[0] = jk_rule(mdl[0], ~xv, mdl[1] ^ xv);
         q_tab.push_back(nt);
         q_jk.push_back(nj);
         q_tag.push_back(origin_tag(mdl));
         mdl = nt;
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_tab.size() > 0) begin
            logic [1:0] et;
            logic [1:0] ej;
            string tg;
            et = q_tab.pop_front();
            ej = q_jk.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if ({state_a, state_b} !== et) begin
               fails++;
               $display("FAIL %s state actual=%b expected=%b", tg, {state_a, state_b}, et);
            end
            checks++;
            if (state_a !== ej[1]) begin
               fails++;
               $display("FAIL R6 bit A actual=%b expected=%b", state_a, ej[1]);
            end
            checks++;
            if (state_b !== ej[0]) begin
               fails++;
               $display("FAIL R7 bit B actual=%b expected=%b", state_b, ej[0]);
            end
         end
      end
   end

   // driver
   initial begin
      logic [7:0] lfsr;
      step(1'b1, 1'b0);   // R1
      step(1'b1, 1'b1);   // R8 with x high
      // directed walk covering all eight state/input pairs
      step(1'b0, 1'b1);   // 00 -> 00
      step(1'b0, 1'b0);   // 00 -> 01
      step(1'b0, 1'b1);   // 01 -> 10
      step(1'b0, 1'b1);   // 10 -> 10
      step(1'b0, 1'b0);   // 10 -> 11
      step(1'b0, 1'b1);   // 11 -> 11
      step(1'b0, 1'b0);   // 11 -> 00
      step(1'b0, 1'b0);   // 00 -> 01
      step(1'b0, 1'b0);   // 01 -> 11
      step(1'b1, 1'b1);   // R8 from 11, x high
      step(1'b0, 1'b0);   // 00 -> 01
      step(1'b1, 1'b0);   // R8 from 01, x low
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);   // now 10
      step(1'b1, 1'b1);   // R8 from 10
      lfsr = 8'hA5;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step((i % 41) == 40, lfsr[0]);
      end
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   // watchdog
   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule